// File: doc/BRIEF.md
# Integer Execute and Decode Unit

This unit sits after the register-read stage of a small 32-bit RISC pipeline. Each cycle it takes one fixed-format instruction word and the two source values already fetched from the register file. It decodes the word, chooses the second ALU operand and computes the arithmetic, logical or shift result. It reports where the result should be written and whether the word was one it understands.

The second operand is either the second register value, the 16-bit immediate sign-extended, or the immediate zero-extended, depending on the instruction. A shift moves the second register value. The amount comes from the instruction's shift-amount field, or from the low five bits of the first register value.

The datapath is combinational. An optional output register stage is chosen by the `OUT_REG` parameter. With the default `OUT_REG = 1`, the results appear one clock after the inputs. Sums and differences wrap modulo 2^32. A signed-overflow flag is reported, but no trap is raised.

Top module: `int_exec_unit`

## Requirements
- R1: The word fields are op = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11, shamt = 10:6, funct = 5:0, with a 16-bit immediate in bits 15:0. The word 0x02324020 decodes as add with rd = 8, and `result` = srcA + srcB.
- R2: For op = 0, funct 32 gives add and 34 gives sub (srcA − srcB), both wrapping modulo 2^32. Funct 36 gives and, 37 gives or, and 38 gives xor. All of these write to rd.
- R3: Funct 39 (op = 0) gives ~(srcA | srcB). With srcB = 0 the result is ~srcA.
- R4: op = 8 adds the sign-extended immediate to srcA and writes to rt. The word 0x2268FFF4 therefore gives srcA − 12 with destination 8.
- R5: op = 12, 13 and 14 compute and, or and xor of srcA with the zero-extended immediate, writing to rt.
- R6: Funct 0, 2 and 3 (op = 0) shift srcB by shamt (0..31). They are left logical, right logical and right arithmetic in that order. Logical shifts fill with 0.
- R7: Funct 4, 6 and 7 perform the same three shifts, but the amount is srcA[4:0]. The upper bits of srcA have no effect.
- R8: An arithmetic right shift copies the sign bit into the vacated positions, so −4 shifted right by 3 gives −1 (0xFFFFFFFF).
- R9: `overflow` is 1 only for add, sub and op = 8 when the signed result does not fit in 32 bits. It is 0 for every other instruction.
- R10: These words are illegal: an op outside {0, 8, 12, 13, 14}; an op = 0 word whose funct is outside the listed set; a fixed shift with a nonzero rs field; any other op = 0 word with a nonzero shamt field. For an illegal word, `illegal` = 1, `writeEn` = 0, `result` = 0 and `destIdx` = 0.
- R11: When the destination index is 0, `writeEn` is 0, while `result` and `destIdx` still show the computed values.
- R12: With OUT_REG = 1, the outputs reflect the inputs of the previous rising clock edge. While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Active-low asynchronous reset |
| instr | input | 32 | Instruction word |
| srcA | input | 32 | Value of the register named by rs |
| srcB | input | 32 | Value of the register named by rt |
| result | output | 32 | Computed result |
| destIdx | output | 5 | Destination register index |
| writeEn | output | 1 | Result should be written back |
| illegal | output | 1 | Word is not a supported instruction |
| overflow | output | 1 | Signed overflow of add, sub or add-immediate |

## Verification
The bench drives immediates with bit 15 set through both extension kinds. A unit that extended the wrong way would corrupt the upper half of an andi or ori result, or turn a negative add-immediate positive. Variable shifts use srcA values with junk in the upper bits, so a unit using the whole register as the amount would shift everything out. Arithmetic right shifts of negative values check that the sign is copied rather than zero-filled. Overflow is driven at both signed limits for add, sub and add-immediate, and alongside wrapping unsigned sums that must not flag. Destination-0 words and several malformed encodings show whether write-enable is properly suppressed.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN   = 32;
  localparam int IDX_W  = 5;
  localparam int IMM_W  = 16;
  localparam int SH_W   = $clog2(XLEN);
  localparam int OPC_W  = 6;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA
  } aluOpT;

  // strobes from control to datapath
  typedef struct packed {
    aluOpT aluOp;
    logic  useImm;
    logic  signExt;
    logic  varShift;
    logic  destRt;
    logic  ovfChk;
    logic  legal;
  } ctrlT;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0] opField,
  input  logic [IDX_W-1:0] rsField,
  input  logic [SH_W-1:0]  shamtField,
  input  logic [OPC_W-1:0] functField,
  output ctrlT             ctrl
);
  logic shamtZero;
  logic rsZero;

  assign shamtZero = (shamtField == '0);
  assign rsZero    = (rsField == '0);

  always_comb begin
    ctrl       = '0;
    ctrl.aluOp = ALU_ADD;
    case (opField)
      6'd0: begin
        case (functField)
          6'd32: begin ctrl.aluOp = ALU_ADD; ctrl.ovfChk = 1'b1; ctrl.legal = shamtZero; end
          6'd34: begin ctrl.aluOp = ALU_SUB; ctrl.ovfChk = 1'b1; ctrl.legal = shamtZero; end
          6'd36: begin ctrl.aluOp = ALU_AND; ctrl.legal = shamtZero; end
          6'd37: begin ctrl.aluOp = ALU_OR;  ctrl.legal = shamtZero; end
          6'd38: begin ctrl.aluOp = ALU_XOR; ctrl.legal = shamtZero; end
          6'd39: begin ctrl.aluOp = ALU_NOR; ctrl.legal = shamtZero; end
          6'd0:  begin ctrl.aluOp = ALU_SLL; ctrl.legal = rsZero; end
          6'd2:  begin ctrl.aluOp = ALU_SRL; ctrl.legal = rsZero; end
          6'd3:  begin ctrl.aluOp = ALU_SRA; ctrl.legal = rsZero; end
          6'd4:  begin ctrl.aluOp = ALU_SLL; ctrl.varShift = 1'b1; ctrl.legal = shamtZero; end
          6'd6:  begin ctrl.aluOp = ALU_SRL; ctrl.varShift = 1'b1; ctrl.legal = shamtZero; end
          6'd7:  begin ctrl.aluOp = ALU_SRA; ctrl.varShift = 1'b1; ctrl.legal = shamtZero; end
          default: ctrl.legal = 1'b0;
        endcase
      end
      6'd8: begin
        ctrl.aluOp   = ALU_ADD;
        ctrl.useImm  = 1'b1;
        ctrl.signExt = 1'b1;
        ctrl.destRt  = 1'b1;
        ctrl.ovfChk  = 1'b1;
        ctrl.legal   = 1'b1;
      end
      6'd12, 6'd13, 6'd14: begin
        ctrl.aluOp  = (opField == 6'd12) ? ALU_AND :
                      (opField == 6'd13) ? ALU_OR : ALU_XOR;
        ctrl.useImm = 1'b1;
        ctrl.destRt = 1'b1;
        ctrl.legal  = 1'b1;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
(
  input  ctrlT             ctrl,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [IMM_W-1:0] imm,
  input  logic [IDX_W-1:0] rtIdx,
  output logic [XLEN-1:0]  result,
  output logic [IDX_W-1:0] destIdx,
  output logic             writeEn,
  output logic             overflow
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0]  immExt;
  logic [XLEN-1:0]  opnd2;
  logic [SH_W-1:0]  shAmt;
  logic [XLEN-1:0]  sum;
  logic [XLEN-1:0]  diff;
  logic [XLEN-1:0]  aluRes;
  logic [IDX_W-1:0] rawDest;
  logic             addOvf;
  logic             subOvf;

  assign immExt = ctrl.signExt ? {{EXT_W{imm[IMM_W-1]}}, imm} : {{EXT_W{1'b0}}, imm};
  assign opnd2  = ctrl.useImm ? immExt : opB;
  assign shAmt  = ctrl.varShift ? opA[SH_W-1:0] : imm[6 +: SH_W];
  assign sum    = opA + opnd2;
  assign diff   = opA - opnd2;

  assign addOvf = (opA[XLEN-1] == opnd2[XLEN-1]) && (sum[XLEN-1] != opA[XLEN-1]);
  assign subOvf = (opA[XLEN-1] != opnd2[XLEN-1]) && (diff[XLEN-1] != opA[XLEN-1]);

  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD: aluRes = sum;
      ALU_SUB: aluRes = diff;
      ALU_AND: aluRes = opA & opnd2;
      ALU_OR:  aluRes = opA | opnd2;
      ALU_XOR: aluRes = opA ^ opnd2;
      ALU_NOR: aluRes = ~(opA | opnd2);
      ALU_SLL: aluRes = opB << shAmt;
      ALU_SRL: aluRes = opB >> shAmt;
      ALU_SRA: aluRes = XLEN'($signed(opB) >>> shAmt);
      default: aluRes = '0;
    endcase
  end

  assign rawDest  = ctrl.destRt ? rtIdx : imm[11 +: IDX_W];
  assign result   = ctrl.legal ? aluRes : '0;
  assign destIdx  = ctrl.legal ? rawDest : '0;
  assign writeEn  = ctrl.legal && (rawDest != '0);
  assign overflow = ctrl.legal && ctrl.ovfChk &&
                    ((ctrl.aluOp == ALU_SUB) ? subOvf : addOvf);
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     instr,
  input  logic [31:0]     srcA,
  input  logic [31:0]     srcB,
  output logic [31:0]     result,
  output logic [4:0]      destIdx,
  output logic            writeEn,
  output logic            illegal,
  output logic            overflow
);
  ctrlT             ctrl;
  logic [XLEN-1:0]  resC;
  logic [IDX_W-1:0] destC;
  logic             weC;
  logic             ovfC;

  exu_decode u_dec (
    .opField    (instr[31:26]),
    .rsField    (instr[25:21]),
    .shamtField (instr[10:6]),
    .functField (instr[5:0]),
    .ctrl       (ctrl)
  );

  exu_datapath u_dp (
    .ctrl     (ctrl),
    .opA      (srcA),
    .opB      (srcB),
    .imm      (instr[15:0]),
    .rtIdx    (instr[20:16]),
    .result   (resC),
    .destIdx  (destC),
    .writeEn  (weC),
    .overflow (ovfC)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result   <= '0;
          destIdx  <= '0;
          writeEn  <= 1'b0;
          illegal  <= 1'b0;
          overflow <= 1'b0;
        end else begin
          result   <= resC;
          destIdx  <= destC;
          writeEn  <= weC;
          illegal  <= !ctrl.legal;
          overflow <= ovfC;
        end
      end
    end else begin : g_comb
      assign result   = resC;
      assign destIdx  = destC;
      assign writeEn  = weC;
      assign illegal  = !ctrl.legal;
      assign overflow = ovfC;
    end
  endgenerate
endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] instr,
  input logic [31:0] srcA,
  input logic [31:0] srcB,
  input logic [31:0] result,
  input logic [4:0]  destIdx,
  input logic        writeEn,
  input logic        illegal,
  input logic        overflow
);
  assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!writeEn && destIdx == 5'd0 && result == 32'd0));

  assert_dest_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> (destIdx != 5'd0));

  assert_ovf_scope_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !illegal);

  generate
    if (OUT_REG) begin : g_seq
      assert_add_fields_R1: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(instr[31:26]) == 6'd0 && $past(instr[5:0]) == 6'd32 &&
         $past(instr[10:6]) == 5'd0 && $past(instr[15:11]) != 5'd0)
        |-> (writeEn && destIdx == $past(instr[15:11]) &&
             result == $past(srcA) + $past(srcB)));

      assert_nor_R3: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(instr[31:26]) == 6'd0 && $past(instr[5:0]) == 6'd39 &&
         $past(instr[10:6]) == 5'd0)
        |-> (result == ~($past(srcA) | $past(srcB))));

      assert_addi_dest_R4: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(instr[31:26]) == 6'd8 && $past(instr[20:16]) != 5'd0)
        |-> (writeEn && destIdx == $past(instr[20:16])));

      assert_sll_R6: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(instr[31:26]) == 6'd0 && $past(instr[5:0]) == 6'd0 &&
         $past(instr[25:21]) == 5'd0)
        |-> (result == ($past(srcB) << $past(instr[10:6]))));

      assert_shift_rs_R10: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(instr[31:26]) == 6'd0 && $past(instr[5:0]) == 6'd0 &&
         $past(instr[25:21]) != 5'd0)
        |-> illegal);
    end
  endgenerate
endmodule

bind int_exec_unit exu_checker #(.OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .instr    (instr),
  .srcA     (srcA),
  .srcB     (srcB),
  .result   (result),
  .destIdx  (destIdx),
  .writeEn  (writeEn),
  .illegal  (illegal),
  .overflow (overflow)
);

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] result;
  logic [4:0]  destIdx;
  logic        writeEn;
  logic        illegal;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic [4:0]  dst;
    logic        we;
    logic        ill;
    logic        ovf;
  } expT;

  expT sb[$];

  always #2 clk = ~clk;

  int_exec_unit u_dut (
    .clk(clk), .rstN(rstN), .instr(instr), .srcA(srcA), .srcB(srcB),
    .result(result), .destIdx(destIdx), .writeEn(writeEn),
    .illegal(illegal), .overflow(overflow)
  );

  function automatic logic [31:0] rWord(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] iWord(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(string tag, logic [31:0] w, logic [31:0] a, logic [31:0] b,
                      logic [31:0] eRes, int eDst, bit eWe, bit eIll, bit eOvf);
    expT e;
    @(negedge clk);
    instr = w; srcA = a; srcB = b;
    e.tag = tag; e.res = eRes; e.dst = 5'(eDst); e.we = eWe; e.ill = eIll; e.ovf = eOvf;
    sb.push_back(e);
  endtask

  // monitor: one registered stage, results valid shortly after the next rising edge
  always @(posedge clk) begin
    #1;
    if (rstN && sb.size() > 0) begin
      expT e;
      e = sb.pop_front();
      check(e.tag, "result",   result,           e.res);
      check(e.tag, "destIdx",  32'(destIdx),     32'(e.dst));
      check(e.tag, "writeEn",  32'(writeEn),     32'(e.we));
      check(e.tag, "illegal",  32'(illegal),     32'(e.ill));
      check(e.tag, "overflow", 32'(overflow),    32'(e.ovf));
    end
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    instr = rWord(1, 2, 3, 0, 32); srcA = 32'h11; srcB = 32'h22;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check("R12", "reset result", result, 32'd0);
    check("R12", "reset flags", {27'd0, destIdx == 5'd0 ? 1'b0 : 1'b1, writeEn, illegal, overflow, 1'b0}, 32'd0);
    rstN = 1'b1;

    // R1 field decode
    send("R1", 32'h02324020, 32'd5, 32'd7, 32'd12, 8, 1, 0, 0);
    // R4 sign-extended add immediate
    send("R4", 32'h2268FFF4, 32'd100, 32'hDEAD, 32'd88, 8, 1, 0, 0);
    send("R4", iWord(8, 1, 9, 16'h8000), 32'd0, 32'd0, 32'hFFFF8000, 9, 1, 0, 0);
    // R2 arithmetic and logic
    send("R2", rWord(1, 2, 3, 0, 32), 32'hFFFFFFFF, 32'd2, 32'd1, 3, 1, 0, 0);
    send("R2", rWord(1, 2, 4, 0, 34), 32'd10, 32'd3, 32'd7, 4, 1, 0, 0);
    send("R2", rWord(1, 2, 5, 0, 36), 32'hFFFF0000, 32'h46A1F0B7, 32'h46A10000, 5, 1, 0, 0);
    send("R2", rWord(1, 2, 6, 0, 37), 32'hFFFF0000, 32'h46A1F0B7, 32'hFFFFF0B7, 6, 1, 0, 0);
    send("R2", rWord(1, 2, 7, 0, 38), 32'hFFFF0000, 32'h46A1F0B7, 32'hB95EF0B7, 7, 1, 0, 0);
    send("R2", rWord(1, 2, 3, 0, 34), 32'd0, 32'd1, 32'hFFFFFFFF, 3, 1, 0, 0);
    // R3 nor
    send("R3", rWord(1, 2, 8, 0, 39), 32'hFFFF0000, 32'h46A1F0B7, 32'h00000F48, 8, 1, 0, 0);
    send("R3", rWord(1, 0, 8, 0, 39), 32'h1234ABCD, 32'd0, ~32'h1234ABCD, 8, 1, 0, 0);
    // R5 zero-extended logical immediates
    send("R5", iWord(12, 1, 10, 16'hFF00), 32'h12345678, 32'd0, 32'h00005600, 10, 1, 0, 0);
    send("R5", iWord(13, 1, 11, 16'h8000), 32'h00000000, 32'd0, 32'h00008000, 11, 1, 0, 0);
    send("R5", iWord(14, 1, 12, 16'hFFFF), 32'hF000FFFF, 32'd0, 32'hF0000000, 12, 1, 0, 0);
    // R6 fixed shifts
    send("R6", rWord(0, 2, 13, 4, 0), 32'hFFFF, 32'h0000000F, 32'h000000F0, 13, 1, 0, 0);
    send("R6", rWord(0, 2, 13, 8, 2), 32'd0, 32'hF0000000, 32'h00F00000, 13, 1, 0, 0);
    send("R6", rWord(0, 2, 13, 31, 0), 32'd0, 32'h00000003, 32'h80000000, 13, 1, 0, 0);
    send("R6", rWord(0, 2, 13, 0, 2), 32'd0, 32'h89ABCDEF, 32'h89ABCDEF, 13, 1, 0, 0);
    // R8 arithmetic right shift
    send("R8", rWord(0, 2, 14, 4, 3), 32'd0, 32'h80000000, 32'hF8000000, 14, 1, 0, 0);
    send("R8", rWord(0, 2, 14, 3, 3), 32'd0, 32'hFFFFFFFC, 32'hFFFFFFFF, 14, 1, 0, 0);
    send("R8", rWord(0, 2, 14, 3, 2), 32'd0, 32'hFFFFFFFC, 32'h1FFFFFFF, 14, 1, 0, 0);
    send("R8", rWord(0, 2, 14, 4, 3), 32'd0, 32'h70000000, 32'h07000000, 14, 1, 0, 0);
    // R7 variable shifts, only srcA[4:0] counts
    send("R7", rWord(1, 2, 15, 0, 4), 32'h00000023, 32'd1, 32'd8, 15, 1, 0, 0);
    send("R7", rWord(1, 2, 15, 0, 6), 32'hFFFFFFE4, 32'd100, 32'd6, 15, 1, 0, 0);
    send("R7", rWord(1, 2, 15, 0, 7), 32'd31, 32'h80000000, 32'hFFFFFFFF, 15, 1, 0, 0);
    send("R7", rWord(1, 2, 15, 0, 4), 32'hFFFFFFE0, 32'h5A5A5A5A, 32'h5A5A5A5A, 15, 1, 0, 0);
    // R9 signed overflow
    send("R9", rWord(1, 2, 16, 0, 32), 32'h7FFFFFFF, 32'd1, 32'h80000000, 16, 1, 0, 1);
    send("R9", rWord(1, 2, 16, 0, 32), 32'h80000000, 32'h80000000, 32'd0, 16, 1, 0, 1);
    send("R9", rWord(1, 2, 16, 0, 34), 32'h80000000, 32'd1, 32'h7FFFFFFF, 16, 1, 0, 1);
    send("R9", rWord(1, 2, 16, 0, 34), 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 16, 1, 0, 1);
    send("R9", iWord(8, 1, 16, 16'h0001), 32'h7FFFFFFF, 32'd0, 32'h80000000, 16, 1, 0, 1);
    send("R9", iWord(8, 1, 16, 16'hFFFF), 32'h80000000, 32'd0, 32'h7FFFFFFF, 16, 1, 0, 1);
    send("R9", rWord(1, 2, 16, 0, 34), 32'h80000000, 32'h80000000, 32'd0, 16, 1, 0, 0);
    send("R9", iWord(14, 1, 16, 16'h0001), 32'h7FFFFFFF, 32'd0, 32'h7FFFFFFE, 16, 1, 0, 0);
    // R10 illegal words
    send("R10", iWord(2, 1, 17, 16'h1234), 32'd1, 32'd2, 32'd0, 0, 0, 1, 0);
    send("R10", iWord(35, 1, 17, 16'h0004), 32'd1, 32'd2, 32'd0, 0, 0, 1, 0);
    send("R10", rWord(1, 2, 17, 0, 24), 32'd1, 32'd2, 32'd0, 0, 0, 1, 0);
    send("R10", rWord(1, 2, 17, 5, 32), 32'h7FFFFFFF, 32'd1, 32'd0, 0, 0, 1, 0);
    send("R10", rWord(3, 2, 17, 4, 0), 32'd1, 32'd2, 32'd0, 0, 0, 1, 0);
    send("R10", rWord(1, 2, 17, 2, 6), 32'd1, 32'd2, 32'd0, 0, 0, 1, 0);
    // R11 destination zero
    send("R11", rWord(1, 2, 0, 0, 32), 32'd3, 32'd4, 32'd7, 0, 0, 0, 0);
    send("R11", iWord(13, 1, 0, 16'h00F0), 32'h0F, 32'd0, 32'hFF, 0, 0, 0, 0);
    // R12 back-to-back latency then idle
    send("R12", rWord(1, 2, 18, 0, 32), 32'd1, 32'd1, 32'd2, 18, 1, 0, 0);
    send("R12", rWord(1, 2, 19, 0, 32), 32'd2, 32'd2, 32'd4, 19, 1, 0, 0);

    @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R12", "async reset result", result, 32'd0);
    check("R12", "async reset writeEn", 32'(writeEn), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule